// File: doc/BRIEF.md
# Diagnostic Output Selector with Clock-Bypass Path

This block drives one diagnostic pin of a clock synthesizer from a 3-bit select code. Most codes pick a constant, a free-running tap, or an internal clock: the serial shift-register bit, a divided reference clock, the feedback-counter pulse, the main synthesized clock, or a quarter-rate copy of that main clock.

One code also changes the clock tree. It places the block in bypass: a slow serial clock takes the place of the VCO clock as the source for both the feedback counter and the post-divider. In that mode the diagnostic pin shows the counter pulse at the serial rate, so a board can step the clock tree at low speed for debug. Moving between the two clock sources goes through a glitch-free multiplexer.

The feedback counter is a programmable divide-by-M counter that reloads from the M input each time it reaches terminal count. The post-divider itself sits outside the block. The block hands it a clock and receives its output back.

Top module: `dbg_out_sel`

## Requirements
- R1: With select code 3'b000 the diagnostic pin equals the shift-register bit input, and follows it in both values.
- R2: Code 3'b001 drives the diagnostic pin to a constant 1, and code 3'b101 drives it to a constant 0.
- R3: Code 3'b010 puts the most significant bit of a free-running 4-bit counter clocked by the reference clock on the pin. This gives exactly one rising edge per 16 reference cycles.
- R4: Code 3'b011 puts the feedback-counter pulse on the pin. The pulse is one source-clock cycle wide and occurs once every M source cycles. A new M value takes effect at the next reload.
- R5: Code 3'b100 puts the post-divider output (the main clock) on the pin.
- R6: Code 3'b111 puts the main clock divided by 4 on the pin. It comes from the top bit of a free-running 2-bit counter clocked by the main clock, giving one rising edge per 4 main-clock cycles.
- R7: Code 3'b110 selects bypass. The divider clock output follows the serial clock, the feedback counter runs from the serial clock, and the pin shows its pulse: one per M serial cycles.
- R8: Every code other than 3'b110 makes the divider clock output follow the VCO clock.
- R9: Switching between the two clock sources never passes a high pulse shorter than the source's own high phase, and the two source enables are never on together.
- R10: While reset is asserted, every counter is held at zero and the feedback pulse is low, so codes 3'b010 and 3'b011 give a low pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| tsel | input | 3 | Diagnostic select code |
| vco_clk | input | 1 | VCO clock, normal source for counter and divider |
| ref_clk | input | 1 | Reference clock |
| ser_clk | input | 1 | Serial clock, bypass source |
| m_val | input | 9 | Feedback divide value M |
| post_div_out | input | 1 | Post-divider output (main clock) |
| shreg_bit | input | 1 | Serial shift-register output bit |
| test_out | output | 1 | Diagnostic pin |
| div_clk_src | output | 1 | Clock delivered to the post-divider |

## Verification
The static codes are tried with the shift-register bit at both levels, so a swapped constant or a swapped code is detected. The clock codes are measured as rising-edge counts over windows that are whole multiples of the expected period. Each count therefore matches only the intended ratio: 16 for the reference tap, M for the counter, 2 for the bench's divide-by-2 post-divider, and 4 for the quarter-rate tap.

Two M values are used, and bypass is measured in counts of serial cycles. This separates a wrong reload value from a wrong clock source. Repeated switches into and out of bypass, while the bench records the narrowest high pulse on the divider clock, expose a multiplexer that cuts a pulse short.

// File: rtl/dbgsel_pkg.sv
package dbgsel_pkg;
   typedef enum logic [2:0] {
      TS_SHIFT   = 3'b000,
      TS_ONE     = 3'b001,
      TS_REFDIV  = 3'b010,
      TS_MCNT    = 3'b011,
      TS_MAIN    = 3'b100,
      TS_ZERO    = 3'b101,
      TS_BYPASS  = 3'b110,
      TS_MAINDIV = 3'b111
   } tsel_e;
endpackage

// File: rtl/clk_glitchless_mux.sv
module clk_glitchless_mux #(
   parameter int SYNC_STAGES = 2
) (
   input  logic rst_n,
   input  logic clk_a,
   input  logic clk_b,
   input  logic sel_b,
   output logic clk_o,
   output logic en_a,
   output logic en_b
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("clk_glitchless_mux: SYNC_STAGES must be at least 2");
   end

   logic [LAST:0] sync_a, sync_b;
   logic req_a, req_b;

   // each side may turn on only once the other side reports off
   assign req_a = ~sel_b & ~sync_b[LAST];
   assign req_b =  sel_b & ~sync_a[LAST];

   // enables move on the falling edge of their own clock, while it is low
   always_ff @(negedge clk_a or negedge rst_n) begin
      if (!rst_n) sync_a <= '0;
      else        sync_a <= {sync_a[LAST-1:0], req_a};
   end

   always_ff @(negedge clk_b or negedge rst_n) begin
      if (!rst_n) sync_b <= '0;
      else        sync_b <= {sync_b[LAST-1:0], req_b};
   end

   assign en_a  = sync_a[LAST];
   assign en_b  = sync_b[LAST];
   assign clk_o = (clk_a & en_a) | (clk_b & en_b);
endmodule

// File: rtl/mod_m_pulse.sv
module mod_m_pulse #(
   parameter int M_W = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [M_W-1:0] m_val,
   output logic           pulse
);
   if (M_W < 2) begin : g_bad_width
      $error("mod_m_pulse: M_W must be at least 2");
   end

   logic [M_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else if (cnt == '0) begin
         cnt   <= (m_val == '0) ? '0 : m_val - 1'b1;
         pulse <= 1'b1;
      end else begin
         cnt   <= cnt - 1'b1;
         pulse <= 1'b0;
      end
   end
endmodule

// File: rtl/pow2_tap.sv
module pow2_tap #(
   parameter int LOG2 = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tap
);
   if (LOG2 < 1) begin : g_bad_log2
      $error("pow2_tap: LOG2 must be at least 1");
   end

   logic [LOG2-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   assign tap = cnt[LOG2-1];
endmodule

// File: rtl/dbg_out_sel.sv
module dbg_out_sel #(
   parameter int M_W           = 9,
   parameter int REF_DIV_LOG2  = 4,
   parameter int MAIN_DIV_LOG2 = 2,
   parameter int SYNC_STAGES   = 2
) (
   input  logic           rst_n,
   input  logic [2:0]     tsel,
   input  logic           vco_clk,
   input  logic           ref_clk,
   input  logic           ser_clk,
   input  logic [M_W-1:0] m_val,
   input  logic           post_div_out,
   input  logic           shreg_bit,
   output logic           test_out,
   output logic           div_clk_src
);
   import dbgsel_pkg::*;

   tsel_e code;
   logic  bypass;
   logic  en_vco, en_ser;
   logic  m_pulse, ref_tap, main_tap;

   assign code   = tsel_e'(tsel);
   assign bypass = (code == TS_BYPASS);

   clk_glitchless_mux #(.SYNC_STAGES(SYNC_STAGES)) u_cmux (
      .rst_n (rst_n),
      .clk_a (vco_clk),
      .clk_b (ser_clk),
      .sel_b (bypass),
      .clk_o (div_clk_src),
      .en_a  (en_vco),
      .en_b  (en_ser)
   );

   mod_m_pulse #(.M_W(M_W)) u_mcnt (
      .clk   (div_clk_src),
      .rst_n (rst_n),
      .m_val (m_val),
      .pulse (m_pulse)
   );

   pow2_tap #(.LOG2(REF_DIV_LOG2)) u_ref_tap (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .tap   (ref_tap)
   );

   pow2_tap #(.LOG2(MAIN_DIV_LOG2)) u_main_tap (
      .clk   (post_div_out),
      .rst_n (rst_n),
      .tap   (main_tap)
   );

   always_comb begin
      unique case (code)
         TS_SHIFT:   test_out = shreg_bit;
         TS_ONE:     test_out = 1'b1;
         TS_REFDIV:  test_out = ref_tap;
         TS_MCNT:    test_out = m_pulse;
         TS_MAIN:    test_out = post_div_out;
         TS_ZERO:    test_out = 1'b0;
         TS_BYPASS:  test_out = m_pulse;
         TS_MAINDIV: test_out = main_tap;
         default:    test_out = 1'b0;
      endcase
   end
endmodule

// File: rtl/dbg_out_sel_chk.sv
module dbg_out_sel_chk #(
   parameter int M_W = 9
) (
   input logic           rst_n,
   input logic           div_clk,
   input logic           ref_clk,
   input logic           pd_clk,
   input logic [M_W-1:0] m_val,
   input logic           mpulse,
   input logic           en_vco,
   input logic           en_ser,
   input logic           ref_tap,
   input logic           main_tap
);
   // R4: pulse lasts one cycle when the loaded M is at least 2
   assert_pulse_width_R4: assert property (@(posedge div_clk) disable iff (!rst_n)
      (mpulse && ($past(m_val) >= 2)) |=> !mpulse);

   // R9: the two clock enables never overlap
   assert_src_exclusive_R9: assert property (@(posedge div_clk) disable iff (!rst_n)
      $onehot0({en_vco, en_ser}));

   // R3: the reference tap stays high for more than one reference cycle
   assert_ref_tap_hold_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(ref_tap) |=> ref_tap);

   // R6: the quarter-rate tap stays high for more than one main-clock cycle
   assert_main_tap_hold_R6: assert property (@(posedge pd_clk) disable iff (!rst_n)
      $rose(main_tap) |=> main_tap);

   // R10: no counter pulse while reset is held
   always_comb begin
      if (!rst_n) assert_reset_quiet_R10: assert (!mpulse);
   end
endmodule

bind dbg_out_sel dbg_out_sel_chk #(.M_W(M_W)) u_chk (
   .rst_n    (rst_n),
   .div_clk  (div_clk_src),
   .ref_clk  (ref_clk),
   .pd_clk   (post_div_out),
   .m_val    (m_val),
   .mpulse   (m_pulse),
   .en_vco   (en_vco),
   .en_ser   (en_ser),
   .ref_tap  (ref_tap),
   .main_tap (main_tap)
);

// File: tb/sim_dbg_out_sel.sv
`timescale 1ns/1ps
module sim_dbg_out_sel;
   logic       rst_n = 1'b0;
   logic [2:0] tsel = 3'b000;
   logic       vco_clk = 1'b0, ref_clk = 1'b0, ser_clk = 1'b0;
   logic [8:0] m_val = 9'd5;
   logic       pd = 1'b0;
   logic       shreg_bit = 1'b0;
   logic       test_out, div_clk_src;

   int checks = 0, fails = 0;
   bit done = 0;

   typedef struct { string req; int val; } item_t;
   item_t exp_q[$];
   int    obs_q[$];

   int test_edges = 0, div_edges = 0, pd_edges = 0;
   realtime t_rise = 0.0, min_w = 1000.0;

   always #2.5 vco_clk = ~vco_clk;   // 200 MHz
   always #13  ref_clk = ~ref_clk;
   always #20  ser_clk = ~ser_clk;

   dbg_out_sel u0 (
      .rst_n(rst_n), .tsel(tsel), .vco_clk(vco_clk), .ref_clk(ref_clk),
      .ser_clk(ser_clk), .m_val(m_val), .post_div_out(pd),
      .shreg_bit(shreg_bit), .test_out(test_out), .div_clk_src(div_clk_src)
   );

   // bench post-divider: divide by 2
   always @(posedge div_clk_src or negedge rst_n)
      if (!rst_n) pd <= 1'b0; else pd <= ~pd;

   always @(posedge test_out)    test_edges++;
   always @(posedge pd)          pd_edges++;
   always @(posedge div_clk_src) begin div_edges++; t_rise = $realtime; end
   always @(negedge div_clk_src)
      if (rst_n && ($realtime - t_rise) < min_w) min_w = $realtime - t_rise;

   task automatic expect_val(input string req, input int val);
      item_t it;
      it.req = req; it.val = val;
      exp_q.push_back(it);
   endtask

   task automatic observe(input int val);
      obs_q.push_back(val);
   endtask

   // scoreboard monitor
   initial forever begin
      item_t it;
      int    o;
      wait (obs_q.size() > 0);
      o  = obs_q.pop_front();
      it = exp_q.pop_front();
      checks++;
      if (o != it.val) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", it.req, o, it.val);
      end
   end

   task automatic sync_neg(input int src);
      case (src)
         0:       @(negedge vco_clk);
         1:       @(negedge ref_clk);
         default: @(negedge ser_clk);
      endcase
   endtask

   task automatic window(input int src, input int ncyc);
      sync_neg(src);
      test_edges = 0; div_edges = 0; pd_edges = 0;
      repeat (ncyc) sync_neg(src);
   endtask

   task automatic level(input string req, input int exp_v);
      #1;
      expect_val(req, exp_v);
      observe(int'(test_out));
   endtask

   initial begin
      // R10: reset state
      shreg_bit = 1'b1;
      #20;
      tsel = 3'b000; level("R10 shift bit during reset", 1);
      tsel = 3'b011; level("R10 counter pulse low in reset", 0);
      tsel = 3'b010; level("R10 ref tap low in reset", 0);
      tsel = 3'b000;
      @(negedge vco_clk); rst_n = 1'b1;
      repeat (10) @(negedge vco_clk);

      // R1
      shreg_bit = 1'b0; level("R1 shift bit 0", 0);
      shreg_bit = 1'b1; level("R1 shift bit 1", 1);
      // R2
      tsel = 3'b001; shreg_bit = 1'b0; level("R2 constant one", 1);
      tsel = 3'b101; shreg_bit = 1'b1; level("R2 constant zero", 0);

      // R3
      tsel = 3'b010;
      window(1, 160);
      expect_val("R3 ref/16 edges", 10); observe(test_edges);

      // R4: two M values
      tsel = 3'b011; m_val = 9'd5;
      repeat (20) @(negedge vco_clk);
      window(0, 50);
      expect_val("R4 M=5 pulses", 10); observe(test_edges);
      m_val = 9'd7;
      repeat (20) @(negedge vco_clk);
      window(0, 70);
      expect_val("R4 M=7 pulses", 10); observe(test_edges);

      // R5
      tsel = 3'b100;
      window(0, 40);
      expect_val("R5 main clock edges", 20); observe(test_edges);

      // R6
      tsel = 3'b111;
      repeat (10) @(negedge vco_clk);
      window(0, 80);
      expect_val("R6 main/4 edges", 10); observe(test_edges);

      // R7: bypass
      m_val = 9'd5;
      tsel  = 3'b110;
      repeat (10) @(negedge ser_clk);
      window(2, 50);
      expect_val("R7 divider clock follows serial", 50); observe(div_edges);
      expect_val("R7 main = serial/2", 25);              observe(pd_edges);
      expect_val("R7 counter pulses at serial rate", 10); observe(test_edges);

      // R8: back to VCO
      tsel = 3'b000;
      repeat (10) @(negedge ser_clk);
      window(0, 40);
      expect_val("R8 divider clock follows VCO", 40); observe(div_edges);
      expect_val("R8 main = VCO/2", 20);              observe(pd_edges);

      // R9: repeated switching
      for (int i = 0; i < 4; i++) begin
         tsel = 3'b110; #123;
         tsel = 3'b011; #157;
      end
      repeat (10) @(negedge ser_clk);
      expect_val("R9 no short pulse on divider clock", 1);
      observe((min_w >= 2.4) ? 1 : 0);

      wait (obs_q.size() == 0);
      #1;
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule